// File: doc/BRIEF.md
# Serial ADC Command Sequencer

This block is the digital control core of a small multiplexed serial A/D converter. A host frames an 8-bit command with an active-low select and clocks it in MSB-first on the serial data input, sampled on rising serial-clock edges. The first four bits are a mode code and the last four are channel information, of which only the two low bits pick a channel. The host asks either for one conversion or for an automatic sequence that steps through the three channel settings in turn. The analog inputs are modelled as two digital sample buses.

Conversions are timed by a free-running oscillator clock that is unrelated to the serial clock. A start request crosses into the oscillator domain as a toggle through two synchronizer flops. The done indication comes back the same way, and then the 8-bit result is latched. The next selected frame shifts the result out MSB-first on falling serial-clock edges, while the same frame shifts the next command in. The command and result paths are bit-serial pins with no valid/ready handshake. A host must not read before busy has fallen, because the block cannot stall the host. The only back-pressure is internal: a command that arrives while a conversion or an unread result is outstanding is held until that result has been read.

Top module: `adc_cmd_seq`

## Requirements
- R1: A command with mode code 4'b1010 and a valid channel code starts exactly one conversion. The 8-bit result is shifted out in the next selected frame, and no further conversion follows.
- R2: The channel code is the last two bits of the command (I1,I0). 2'b00 converts the channel 0 sample, 2'b10 converts the channel 1 sample, and 2'b01 converts the difference channel 0 minus channel 1.
- R3: Command bits I3 and I2 (command bits 3 and 2) have no effect on channel selection or result.
- R4: In the difference setting, a channel 0 sample below the channel 1 sample gives a result of 8'h00.
- R5: Channel code 2'b11 with mode code 4'b1010 or 4'b1011 starts no conversion and sets err. err stays high until the next command with a valid channel code, which clears it.
- R6: Mode code 4'b1011 starts an automatic sequence at the given channel code. Each following conversion uses the next setting in the order 00, 01, 10, 00. It starts only after the previous result has been fully shifted out. The sequence stops when a new mode 4'b1010 or 4'b1011 command is received.
- R7: A conversion occupies CONV_CYC (default 18) oscillator clock cycles, counted on osc_clk. busy is therefore high for at least CONV_CYC oscillator periods.
- R8: busy rises when a conversion starts and falls when its result is latched. A valid command received while busy or while a result is unread is held. It starts after that result has been shifted out.
- R9: Raising cs_n before eight bits have been clocked in discards the partial command. The next frame starts a new word.
- R10: sdo presents result bit 7 after the first falling edge of a selected frame, then one lower bit per falling edge. sdo is 0 when deselected or when no result is waiting.
- R11: A command with any mode code other than 4'b1010 or 4'b1011 has no effect: no conversion, and err unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock, command bits sampled on rising edges |
| osc_clk | input | 1 | Conversion oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial command input, MSB first |
| sdo | output | 1 | Serial result output, MSB first, updated on falling edges |
| ch0_sample | input | RES_W | Digitised level of analog channel 0 |
| ch1_sample | input | RES_W | Digitised level of analog channel 1 |
| busy | output | 1 | High from conversion start until its result is latched |
| err | output | 1 | Sticky invalid-channel flag |

## Verification
Some rules are checked on every cycle. A conversion never starts while busy or while a result is unread, and busy only falls together with a newly waiting result. An invalid channel code sets err and starts nothing, an unknown mode code leaves err untouched, and sdo stays low after a deselected falling edge. Other behaviour only shows in the bench's scenarios: the result values for every channel and don't-care bit combination, the negative-difference clamp, the conversion duration on the oscillator clock, the order of the automatic sequence and the hand-off to a held command, and the discarding of a cut-off frame.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;
  typedef enum logic [1:0] {
    CH_SE0  = 2'b00,
    CH_DIFF = 2'b01,
    CH_SE1  = 2'b10,
    CH_BAD  = 2'b11
  } chan_e;

  function automatic chan_e next_chan(chan_e c);
    case (c)
      CH_SE0:  return CH_DIFF;
      CH_DIFF: return CH_SE1;
      default: return CH_SE0;
    endcase
  endfunction
endpackage

// File: rtl/adc_cmd_rx.sv
module adc_cmd_rx #(
  parameter int MODE_W = 4,
  parameter int INFO_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sdi,
  output logic              word_valid,
  output logic [MODE_W-1:0] word_mode,
  output logic [1:0]        word_chan
);
  localparam int WORD_W = MODE_W + INFO_W;
  localparam int CW     = $clog2(WORD_W);

  logic [WORD_W-2:0] sr;
  logic [CW-1:0]     cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr         <= '0;
      cnt        <= '0;
      word_valid <= 1'b0;
      word_mode  <= '0;
      word_chan  <= '0;
    end else begin
      word_valid <= 1'b0;
      if (cs_n) begin
        cnt <= '0;
      end else begin
        sr <= {sr[WORD_W-3:0], sdi};
        if (cnt == CW'(WORD_W - 1)) begin
          cnt        <= '0;
          word_valid <= 1'b1;
          word_mode  <= sr[WORD_W-2:INFO_W-1];
          word_chan  <= {sr[0], sdi};
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_cmd_pkg::*;
#(
  parameter int              MODE_W      = 4,
  parameter int              RES_W       = 8,
  parameter logic [MODE_W-1:0] MODE_SINGLE = 4'b1010,
  parameter logic [MODE_W-1:0] MODE_AUTO   = 4'b1011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [MODE_W-1:0] word_mode,
  input  logic [1:0]        word_chan,
  input  logic              ack_tog_async,
  input  logic [RES_W-1:0]  result_async,
  input  logic              take_tog,
  output logic              busy,
  output logic              err,
  output logic              req_tog,
  output chan_e             conv_ch,
  output logic [RES_W-1:0]  res_hold,
  output logic              rdy_tog,
  output logic              pend
);
  logic  ack_s1, ack_s2, ack_s3, ack_edge;
  logic  mode_ok, auto_en, held, held_auto;
  chan_e held_ch, code;

  assign code     = chan_e'(word_chan);
  assign mode_ok  = (word_mode == MODE_SINGLE) || (word_mode == MODE_AUTO);
  assign ack_edge = ack_s2 ^ ack_s3;
  assign pend     = rdy_tog ^ take_tog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ack_s1, ack_s2, ack_s3} <= '0;
      busy      <= 1'b0;
      err       <= 1'b0;
      req_tog   <= 1'b0;
      conv_ch   <= CH_SE0;
      res_hold  <= '0;
      rdy_tog   <= 1'b0;
      auto_en   <= 1'b0;
      held      <= 1'b0;
      held_auto <= 1'b0;
      held_ch   <= CH_SE0;
    end else begin
      ack_s1 <= ack_tog_async;
      ack_s2 <= ack_s1;
      ack_s3 <= ack_s2;
      if (ack_edge) begin
        busy     <= 1'b0;
        res_hold <= result_async;
        rdy_tog  <= ~rdy_tog;
      end
      if (word_valid && mode_ok) begin
        auto_en <= 1'b0;
        if (code == CH_BAD) begin
          err  <= 1'b1;
          held <= 1'b0;
        end else begin
          err       <= 1'b0;
          held      <= 1'b1;
          held_auto <= (word_mode == MODE_AUTO);
          held_ch   <= code;
        end
      end else if (!busy && !pend) begin
        if (held) begin
          held    <= 1'b0;
          auto_en <= held_auto;
          conv_ch <= held_ch;
          req_tog <= ~req_tog;
          busy    <= 1'b1;
        end else if (auto_en) begin
          conv_ch <= next_chan(conv_ch);
          req_tog <= ~req_tog;
          busy    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_conv_core.sv
module adc_conv_core
  import adc_cmd_pkg::*;
#(
  parameter int RES_W    = 8,
  parameter int CONV_CYC = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_tog_async,
  input  chan_e            conv_ch,
  input  logic [RES_W-1:0] smp0,
  input  logic [RES_W-1:0] smp1,
  output logic             ack_tog,
  output logic [RES_W-1:0] result
);
  localparam int CNT_W = $clog2(CONV_CYC);

  logic             r_s1, r_s2, r_s3, start, active;
  logic [CNT_W-1:0] cnt;
  chan_e            ch_l;
  logic [RES_W-1:0] value;

  assign start = r_s2 ^ r_s3;

  always_comb begin
    case (ch_l)
      CH_SE0:  value = smp0;
      CH_SE1:  value = smp1;
      CH_DIFF: value = (smp0 >= smp1) ? (smp0 - smp1) : '0;
      default: value = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {r_s1, r_s2, r_s3} <= '0;
      active  <= 1'b0;
      cnt     <= '0;
      ch_l    <= CH_SE0;
      ack_tog <= 1'b0;
      result  <= '0;
    end else begin
      r_s1 <= req_tog_async;
      r_s2 <= r_s1;
      r_s3 <= r_s2;
      if (start) begin
        active <= 1'b1;
        cnt    <= '0;
        ch_l   <= conv_ch;
      end else if (active) begin
        if (cnt == CNT_W'(CONV_CYC - 1)) begin
          active  <= 1'b0;
          result  <= value;
          ack_tog <= ~ack_tog;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_tx_shift.sv
module adc_tx_shift #(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             pend,
  input  logic [RES_W-1:0] res_hold,
  output logic             sdo,
  output logic             take_tog
);
  localparam int CW = $clog2(RES_W);

  logic [CW-1:0] cnt;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      sdo      <= 1'b0;
      take_tog <= 1'b0;
    end else if (cs_n) begin
      cnt <= '0;
      sdo <= 1'b0;
    end else if (pend) begin
      sdo <= res_hold[CW'(RES_W - 1) - cnt];
      if (cnt == CW'(RES_W - 1)) begin
        cnt      <= '0;
        take_tog <= ~take_tog;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      sdo <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_cmd_seq.sv
module adc_cmd_seq
  import adc_cmd_pkg::*;
#(
  parameter int RES_W    = 8,
  parameter int CONV_CYC = 18,
  parameter int MODE_W   = 4,
  parameter int INFO_W   = 4
) (
  input  logic             sclk,
  input  logic             osc_clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sdi,
  output logic             sdo,
  input  logic [RES_W-1:0] ch0_sample,
  input  logic [RES_W-1:0] ch1_sample,
  output logic             busy,
  output logic             err
);
  logic              word_valid, req_tog, ack_tog, rdy_tog, take_tog, pend;
  logic [MODE_W-1:0] word_mode;
  logic [1:0]        word_chan;
  logic [RES_W-1:0]  result, res_hold;
  chan_e             conv_ch;

  adc_cmd_rx #(.MODE_W(MODE_W), .INFO_W(INFO_W)) u_rx (
    .clk(sclk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi),
    .word_valid(word_valid), .word_mode(word_mode), .word_chan(word_chan)
  );

  adc_seq_ctrl #(.MODE_W(MODE_W), .RES_W(RES_W)) u_ctrl (
    .clk(sclk), .rst_n(rst_n), .word_valid(word_valid), .word_mode(word_mode),
    .word_chan(word_chan), .ack_tog_async(ack_tog), .result_async(result),
    .take_tog(take_tog), .busy(busy), .err(err), .req_tog(req_tog),
    .conv_ch(conv_ch), .res_hold(res_hold), .rdy_tog(rdy_tog), .pend(pend)
  );

  adc_conv_core #(.RES_W(RES_W), .CONV_CYC(CONV_CYC)) u_conv (
    .clk(osc_clk), .rst_n(rst_n), .req_tog_async(req_tog), .conv_ch(conv_ch),
    .smp0(ch0_sample), .smp1(ch1_sample), .ack_tog(ack_tog), .result(result)
  );

  adc_tx_shift #(.RES_W(RES_W)) u_tx (
    .clk(sclk), .rst_n(rst_n), .cs_n(cs_n), .pend(pend), .res_hold(res_hold),
    .sdo(sdo), .take_tog(take_tog)
  );
endmodule

// File: rtl/adc_cmd_seq_chk.sv
module adc_cmd_seq_chk #(
  parameter int MODE_W = 4
) (
  input logic              sclk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sdo,
  input logic              busy,
  input logic              err,
  input logic              req_tog,
  input logic              pend,
  input logic              word_valid,
  input logic [MODE_W-1:0] word_mode,
  input logic [1:0]        word_chan
);
  logic known, bad_cmd;
  assign known   = (word_mode == 4'b1010) || (word_mode == 4'b1011);
  assign bad_cmd = word_valid && known && (word_chan == 2'b11);

  p_launch_idle_r8: assert property (@(posedge sclk) disable iff (!rst_n)
    (req_tog != $past(req_tog)) |-> (!$past(busy) && !$past(pend)));

  p_busy_ends_with_result_r8: assert property (@(posedge sclk) disable iff (!rst_n)
    $fell(busy) |-> pend);

  p_bad_code_sets_err_r5: assert property (@(posedge sclk) disable iff (!rst_n)
    bad_cmd |=> err);

  p_bad_code_no_start_r5: assert property (@(posedge sclk) disable iff (!rst_n)
    bad_cmd |=> (req_tog == $past(req_tog)));

  p_unknown_mode_inert_r11: assert property (@(posedge sclk) disable iff (!rst_n)
    (word_valid && !known) |=> $stable(err));

  p_sdo_quiet_r10: assert property (@(negedge sclk) disable iff (!rst_n)
    cs_n |=> !sdo);
endmodule

bind adc_cmd_seq adc_cmd_seq_chk #(.MODE_W(MODE_W)) u_chk (
  .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .sdo(sdo), .busy(busy), .err(err),
  .req_tog(req_tog), .pend(pend), .word_valid(word_valid),
  .word_mode(word_mode), .word_chan(word_chan)
);

// File: tb/sim_adc_cmd_seq.sv
`timescale 1ns/1ps
module sim_adc_cmd_seq;
  localparam int RES_W = 8;
  localparam int CONV_CYC = 18;
  localparam real OSC_P = 7.0;

  logic sclk = 0, osc_clk = 0, rst_n = 0, cs_n = 1, sdi = 0;
  logic sdo, busy, err;
  logic [RES_W-1:0] s0 = 0, s1 = 0;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #2 sclk = ~sclk;
  always #(OSC_P/2) osc_clk = ~osc_clk;

  adc_cmd_seq #(.RES_W(RES_W), .CONV_CYC(CONV_CYC)) u0 (
    .sclk(sclk), .osc_clk(osc_clk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .ch0_sample(s0), .ch1_sample(s1), .busy(busy), .err(err));

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = 0;
    @(negedge sclk); #1;
    cs_n = 0;
    for (int i = 0; i < nbits; i++) begin
      sdi = tx[7-i];
      @(posedge sclk); @(negedge sclk); #1;
      rx[7-i] = sdo;
    end
    cs_n = 1; sdi = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge sclk);
    #1;
  endtask

  // waits for busy to rise then fall; returns cycles spent high
  task automatic wait_done(output int hi);
    int guard = 0;
    hi = 0;
    while (!busy && guard < 200) begin @(negedge sclk); #1; guard++; end
    while (busy && hi < 400) begin @(negedge sclk); #1; hi++; end
  endtask

  function automatic int expect_val(int code, int a, int b);
    case (code)
      0: return a;
      2: return b;
      1: return (a >= b) ? a - b : 0;
      default: return 0;
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    int hi, e;
    idle(3);
    check("reset busy", busy, 0);
    check("reset err", err, 0);
    check("reset sdo R10", sdo, 0);
    #1 rst_n = 1;
    idle(3);
    frame(8'h00, 8, rx);
    check("empty read R10", rx, 0);

    // sweep: don't-care bits, channel codes, sample pairs (R1 R2 R3 R4 R5 R7)
    for (int hb = 0; hb < 4; hb++)
      for (int code = 0; code < 4; code++)
        for (int p = 0; p < 2; p++) begin
          s0 = RES_W'((hb*61 + code*17 + p*89 + 3) & 255);
          s1 = RES_W'((hb*29 + code*53 + p*131 + 7) & 255);
          frame({4'b1010, 2'(hb), 2'(code)}, 8, rx);
          if (code == 3) begin
            hi = 0;
            for (int k = 0; k < 80; k++) begin @(negedge sclk); #1; if (busy) hi++; end
            check("bad code no start R5", hi, 0);
            check("bad code err R5", err, 1);
            frame(8'h00, 8, rx);
            check("bad code no result R5", rx, 0);
          end else begin
            wait_done(hi);
            check("valid clears err R5", err, 0);
            n_cmp++;
            if (hi < 32 || hi > 48) begin
              n_bad++;
              $display("FAIL R7 busy cycles: actual %0d expected 32..48", hi);
            end
            e = expect_val(code, s0, s1);
            frame(8'h00, 8, rx);
            check("result R1 R2 R3 R4", rx, e);
            idle(60);
            check("single stops R1", busy, 0);
          end
        end

    // explicit negative difference R4
    s0 = 8'd10; s1 = 8'd200;
    frame(8'b1010_0001, 8, rx); wait_done(hi);
    frame(8'h00, 8, rx);
    check("negative diff R4", rx, 0);

    // unknown mode leaves err set R11
    frame(8'b1010_0011, 8, rx); idle(5);
    check("err set R5", err, 1);
    frame(8'b0011_0000, 8, rx); idle(80);
    check("unknown mode busy R11", busy, 0);
    check("unknown mode err R11", err, 1);
    frame(8'b1111_0010, 8, rx); idle(80);
    check("unknown mode 1111 R11", busy, 0);
    frame(8'h00, 8, rx);
    check("unknown mode no result R11", rx, 0);

    // held command R8
    s0 = 8'd150; s1 = 8'd33;
    frame(8'b1010_0000, 8, rx);
    idle(2);
    check("busy after start R8", busy, 1);
    frame(8'b1010_1110, 8, rx);
    wait_done(hi);
    frame(8'h00, 8, rx);
    check("first of held pair R8", rx, 150);
    wait_done(hi);
    check("held launched R8", hi > 0, 1);
    frame(8'h00, 8, rx);
    check("held result R8", rx, 33);

    // cut-off frame R9
    frame(8'b1010_0000, 4, rx);
    idle(2);
    frame(8'h00, 8, rx);
    idle(80);
    check("partial discarded R9", busy, 0);
    frame(8'h00, 8, rx);
    check("partial no result R9", rx, 0);

    // automatic sequence R6
    s0 = 8'd200; s1 = 8'd60;
    frame(8'b1011_0010, 8, rx);
    for (int k = 0; k < 5; k++) begin
      int seq[5] = '{60, 200, 140, 60, 200};
      wait_done(hi);
      frame(8'h00, 8, rx);
      check("auto order R6", rx, seq[k]);
    end
    idle(3);
    check("auto relaunch after drain R6", busy, 1);
    frame(8'b1010_0010, 8, rx);
    wait_done(hi);
    frame(8'h00, 8, rx);
    check("auto last before stop R6", rx, 140);
    wait_done(hi);
    frame(8'h00, 8, rx);
    check("stop command result R6", rx, 60);
    idle(100);
    check("auto stopped R6", busy, 0);
    frame(8'h00, 8, rx);
    check("auto stopped no result R6", rx, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule